// File: doc/BRIEF.md
# Processor Status and Mode Register

This block holds the eight status flags of a 16-bit processor core, together with a separate bit that selects an 8-bit compatibility (emulation) mode. Each cycle it takes one operation. The operation can update single flags from the ALU, clear or set a group of flags from an immediate mask, load the whole status byte from a stack pull, set the flags from a compare, or swap the carry flag with the emulation bit. The register contents are always visible as a byte so that the stack logic can push them.

Two of the flags set the operand widths for the rest of the datapath: one for the accumulator and one for the index registers. Both are driven out as registered width controls. While emulation mode is active, both width flags are held at 1, so the core always runs with 8-bit operands. In emulation mode the index-width bit position means "break" rather than "index size". When the index-width flag goes from 0 to 1, a one-cycle strobe is raised so that the index registers can drop their upper bytes. The ALU, the index registers and the stack are outside this block.

Top module: `psr_mode_reg`

## Requirements
- R1: A synchronous active-high reset sets `status_q` to 0x30 and `emu_q` to 1, sets `acc8` and `idx8` to 1, and sets `idx_hi_clr` to 0.
- R2: The status bit positions are: negative 7, overflow 6, accumulator-width 5, index-width 4, decimal 3, interrupt-mask 2, zero 1, carry 0. `acc8` equals bit 5 and `idx8` equals bit 4. Every output shows the effect of an operation in the cycle after the clock edge that accepts it.
- R3: Operation code 1 (mask clear) clears every status bit whose `op_mask` bit is 1 and leaves all other bits unchanged.
- R4: Operation code 2 (mask set) sets every status bit whose `op_mask` bit is 1 and leaves all other bits unchanged.
- R5: While `emu_q` is 1, status bits 5 and 4 read 1 after any operation, including a mask clear or a whole-byte load.
- R6: Operation code 3 (exchange) copies the old carry into `emu_q` and the old `emu_q` into carry. When the new `emu_q` is 1, bits 5 and 4 are forced to 1.
- R7: Operation code 4 (load) replaces the whole status byte with `op_mask`, subject to R5.
- R8: Operation code 5 (flag update) writes `alu_flags` into the flags selected by `alu_wen`. Bit 3 maps to negative, bit 2 to overflow, bit 1 to zero and bit 0 to carry. Unselected flags keep their values.
- R9: Operation code 6 (compare) subtracts `cmp_mem` from `cmp_reg` at a width of 8 or 16 bits. The width is 8 when the selected width flag is 1; the selected flag is index-width if `cmp_idx` is 1 and accumulator-width otherwise. Zero is set when the truncated difference is 0. Carry is set when the truncated register value is greater than or equal to the truncated memory value (unsigned). Negative takes the top bit of the truncated difference.
- R10: `idx_hi_clr` is 1 for exactly the one cycle in which bit 4 has just changed from 0 to 1, and is 0 at all other times.
- R11: When `op_valid` is 0, or the operation code is 0 or 7, neither the status byte nor `emu_q` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies the operation for this cycle |
| op_code | input | 3 | Operation selector (see R3 to R11) |
| op_mask | input | 8 | Immediate mask, or the byte for a whole-byte load |
| alu_wen | input | 4 | Per-flag write enables for N, V, Z, C |
| alu_flags | input | 4 | New values for N, V, Z, C |
| cmp_reg | input | 16 | Register operand of a compare |
| cmp_mem | input | 16 | Memory operand of a compare |
| cmp_idx | input | 1 | Compare width follows index-width (1) or accumulator-width (0) |
| status_q | output | 8 | Current status byte |
| emu_q | output | 1 | Emulation-mode bit |
| acc8 | output | 1 | Accumulator operates at 8 bits |
| idx8 | output | 1 | Index registers operate at 8 bits |
| idx_hi_clr | output | 1 | One-cycle strobe to clear index upper bytes |

## Verification
Mask clear and mask set are tried with all-ones masks and with single-bit masks, in both modes. This separates the emulation lock on the width bits from ordinary bit updates. Compares use operand pairs whose low bytes agree while the high bytes differ, so an 8-bit result and a 16-bit result disagree; this shows the width is really taken from the flag that `cmp_idx` selects. Exchanges are run in both directions. The strobe is checked on a real 0-to-1 change of the index-width bit and on a repeated set that makes no change. Idle cycles and reserved codes are placed between operations to show that nothing moves without a valid operation.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W = 8;
  localparam int ALU_W  = 4;
  localparam int B_N = 7;
  localparam int B_V = 6;
  localparam int B_M = 5;
  localparam int B_X = 4;
  localparam int B_D = 3;
  localparam int B_I = 2;
  localparam int B_Z = 1;
  localparam int B_C = 0;
  localparam logic [FLAG_W-1:0] RESET_STATUS = 8'h30;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CLR  = 3'd1,
    OP_SET  = 3'd2,
    OP_XCE  = 3'd3,
    OP_LOAD = 3'd4,
    OP_ALU  = 3'd5,
    OP_CMP  = 3'd6,
    OP_RSV  = 3'd7
  } psr_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } cmp_flags_t;

  // ALU enable/value bit i maps onto this status position
  function automatic int alu_pos(input int i);
    case (i)
      3:       return B_N;
      2:       return B_V;
      1:       return B_Z;
      default: return B_C;
    endcase
  endfunction
endpackage

// File: rtl/psr_cmp_unit.sv
module psr_cmp_unit
  import psr_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] reg_val,
  input  logic [WIDE_W-1:0] mem_val,
  input  logic              narrow,
  output cmp_flags_t        flags
);
  logic [NARROW_W:0] diff_n;
  logic [WIDE_W:0]   diff_w;

  // extra top bit carries the borrow out of the subtraction
  assign diff_n = {1'b0, reg_val[NARROW_W-1:0]} - {1'b0, mem_val[NARROW_W-1:0]};
  assign diff_w = {1'b0, reg_val} - {1'b0, mem_val};

  always_comb begin
    if (narrow) begin
      flags.n = diff_n[NARROW_W-1];
      flags.z = (diff_n[NARROW_W-1:0] == '0);
      flags.c = ~diff_n[NARROW_W];
    end else begin
      flags.n = diff_w[WIDE_W-1];
      flags.z = (diff_w[WIDE_W-1:0] == '0);
      flags.c = ~diff_w[WIDE_W];
    end
  end
endmodule

// File: rtl/psr_next_logic.sv
module psr_next_logic
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] cur_st,
  input  logic              cur_emu,
  input  logic              op_valid,
  input  psr_op_e           op,
  input  logic [FLAG_W-1:0] mask,
  input  logic [ALU_W-1:0]  alu_wen,
  input  logic [ALU_W-1:0]  alu_flags,
  input  cmp_flags_t        cmp_flags,
  output logic [FLAG_W-1:0] nxt_st,
  output logic              nxt_emu
);
  logic [FLAG_W-1:0] raw_st;
  logic              raw_emu;
  logic [FLAG_W-1:0] alu_st;

  // per-flag merge of ALU results, one slice per enable bit
  for (genvar i = 0; i < ALU_W; i++) begin : g_alu
    localparam int POS = alu_pos(i);
    assign alu_st[POS] = alu_wen[i] ? alu_flags[i] : cur_st[POS];
  end
  assign alu_st[B_M] = cur_st[B_M];
  assign alu_st[B_X] = cur_st[B_X];
  assign alu_st[B_D] = cur_st[B_D];
  assign alu_st[B_I] = cur_st[B_I];

  always_comb begin
    raw_st  = cur_st;
    raw_emu = cur_emu;
    if (op_valid) begin
      case (op)
        OP_CLR:  raw_st = cur_st & ~mask;
        OP_SET:  raw_st = cur_st | mask;
        OP_LOAD: raw_st = mask;
        OP_XCE: begin
          raw_emu      = cur_st[B_C];
          raw_st[B_C]  = cur_emu;
        end
        OP_ALU:  raw_st = alu_st;
        OP_CMP: begin
          raw_st[B_N] = cmp_flags.n;
          raw_st[B_Z] = cmp_flags.z;
          raw_st[B_C] = cmp_flags.c;
        end
        default: ;
      endcase
    end
    nxt_st  = raw_st;
    nxt_emu = raw_emu;
    if (raw_emu) begin
      nxt_st[B_M] = 1'b1;
      nxt_st[B_X] = 1'b1;
    end
  end
endmodule

// File: rtl/psr_mode_reg.sv
module psr_mode_reg
  import psr_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [7:0]        op_mask,
  input  logic [3:0]        alu_wen,
  input  logic [3:0]        alu_flags,
  input  logic [WIDE_W-1:0] cmp_reg,
  input  logic [WIDE_W-1:0] cmp_mem,
  input  logic              cmp_idx,
  output logic [7:0]        status_q,
  output logic              emu_q,
  output logic              acc8,
  output logic              idx8,
  output logic              idx_hi_clr
);
  cmp_flags_t        cmp_flags;
  logic              cmp_narrow;
  logic [FLAG_W-1:0] nxt_st;
  logic              nxt_emu;

  assign cmp_narrow = cmp_idx ? status_q[B_X] : status_q[B_M];

  psr_cmp_unit #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_cmp (
    .reg_val (cmp_reg),
    .mem_val (cmp_mem),
    .narrow  (cmp_narrow),
    .flags   (cmp_flags)
  );

  psr_next_logic u_next (
    .cur_st    (status_q),
    .cur_emu   (emu_q),
    .op_valid  (op_valid),
    .op        (psr_op_e'(op_code)),
    .mask      (op_mask),
    .alu_wen   (alu_wen),
    .alu_flags (alu_flags),
    .cmp_flags (cmp_flags),
    .nxt_st    (nxt_st),
    .nxt_emu   (nxt_emu)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= RESET_STATUS;
      emu_q      <= 1'b1;
      acc8       <= RESET_STATUS[B_M];
      idx8       <= RESET_STATUS[B_X];
      idx_hi_clr <= 1'b0;
    end else begin
      status_q   <= nxt_st;
      emu_q      <= nxt_emu;
      acc8       <= nxt_st[B_M];
      idx8       <= nxt_st[B_X];
      idx_hi_clr <= ~status_q[B_X] & nxt_st[B_X];
    end
  end
endmodule

// File: rtl/psr_mode_reg_chk.sv
module psr_mode_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [2:0] op_code,
  input logic [7:0] op_mask,
  input logic [7:0] status_q,
  input logic       emu_q,
  input logic       idx8,
  input logic       idx_hi_clr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (status_q == 8'h30 && emu_q && !idx_hi_clr));

  assert_emu_width_lock_R5: assert property (@(posedge clk) disable iff (rst)
    emu_q |-> (status_q[5:4] == 2'b11));

  assert_mask_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd1) |=>
      ((status_q & $past(op_mask) & ~(emu_q ? 8'h30 : 8'h00)) == 8'h00));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |=>
      ((status_q & $past(op_mask)) == $past(op_mask)));

  assert_exchange_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd3) |=>
      (emu_q == $past(status_q[0]) && status_q[0] == $past(emu_q)));

  assert_idx_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    idx_hi_clr |-> (idx8 && !$past(idx8)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(status_q) && $stable(emu_q)));
endmodule

bind psr_mode_reg psr_mode_reg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_mask    (op_mask),
  .status_q   (status_q),
  .emu_q      (emu_q),
  .idx8       (idx8),
  .idx_hi_clr (idx_hi_clr)
);

// File: tb/psr_mode_reg_tb.sv
`timescale 1ns/1ps
module psr_mode_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [7:0]  op_mask = 8'h00;
  logic [3:0]  alu_wen = 4'h0;
  logic [3:0]  alu_flags = 4'h0;
  logic [15:0] cmp_reg = 16'h0;
  logic [15:0] cmp_mem = 16'h0;
  logic        cmp_idx = 1'b0;
  logic [7:0]  status_q;
  logic        emu_q, acc8, idx8, idx_hi_clr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] st;
    logic       emu;
    logic       strobe;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] m_st;
  logic       m_emu;

  always #2 clk = ~clk;

  psr_mode_reg u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_mask(op_mask), .alu_wen(alu_wen), .alu_flags(alu_flags),
    .cmp_reg(cmp_reg), .cmp_mem(cmp_mem), .cmp_idx(cmp_idx),
    .status_q(status_q), .emu_q(emu_q), .acc8(acc8), .idx8(idx8),
    .idx_hi_clr(idx_hi_clr)
  );

  // monitor: one expected item per accepted clock edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      #1;
      checks++;
      if (status_q !== e.st || emu_q !== e.emu || idx_hi_clr !== e.strobe ||
          acc8 !== e.st[5] || idx8 !== e.st[4]) begin
        errors++;
        $display("FAIL %s: got st=%02h emu=%b strb=%b acc8=%b idx8=%b exp st=%02h emu=%b strb=%b",
                 e.tag, status_q, emu_q, idx_hi_clr, acc8, idx8, e.st, e.emu, e.strobe);
      end
    end
  end

  task automatic drive(input logic v, input logic [2:0] op, input logic [7:0] mask,
                       input logic [3:0] wen, input logic [3:0] fl,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic idx, input string tag);
    logic [7:0] n;
    logic       ne;
    logic       narrow;
    exp_t       e;
    @(negedge clk);
    op_valid = v; op_code = op; op_mask = mask; alu_wen = wen;
    alu_flags = fl; cmp_reg = a; cmp_mem = b; cmp_idx = idx;
    n = m_st; ne = m_emu;
    if (v) begin
      case (op)
        3'd1: n = m_st & ~mask;
        3'd2: n = m_st | mask;
        3'd3: begin ne = m_st[0]; n[0] = m_emu; end
        3'd4: n = mask;
        3'd5: begin
          if (wen[3]) n[7] = fl[3];
          if (wen[2]) n[6] = fl[2];
          if (wen[1]) n[1] = fl[1];
          if (wen[0]) n[0] = fl[0];
        end
        3'd6: begin
          narrow = idx ? m_st[4] : m_st[5];
          if (narrow) begin
            n[1] = (a[7:0] == b[7:0]);
            n[0] = (a[7:0] >= b[7:0]);
            n[7] = ((a[7:0] - b[7:0]) & 8'h80) != 0;
          end else begin
            n[1] = (a == b);
            n[0] = (a >= b);
            n[7] = ((a - b) & 16'h8000) != 0;
          end
        end
        default: ;
      endcase
    end
    if (ne) n[5:4] = 2'b11;
    e.st = n; e.emu = ne; e.strobe = !m_st[4] && n[4]; e.tag = tag;
    exp_q.push_back(e);
    m_st = n; m_emu = ne;
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_st = 8'h30; m_emu = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (status_q !== 8'h30 || emu_q !== 1'b1 || acc8 !== 1'b1 || idx8 !== 1'b1 || idx_hi_clr !== 1'b0) begin
      errors++;
      $display("FAIL R1: got st=%02h emu=%b exp st=30 emu=1", status_q, emu_q);
    end
    drive(1, 3'd1, 8'hFF, 0, 0, 0, 0, 0, "R5 clear-all in emulation keeps width bits");
    drive(1, 3'd4, 8'h00, 0, 0, 0, 0, 0, "R7 R5 load zero in emulation");
    drive(1, 3'd3, 8'h00, 0, 0, 0, 0, 0, "R6 exchange into native");
    drive(1, 3'd1, 8'h30, 0, 0, 0, 0, 0, "R3 clear width bits native");
    drive(0, 3'd2, 8'hFF, 0, 0, 0, 0, 0, "R11 invalid op holds");
    drive(1, 3'd7, 8'hFF, 0, 0, 0, 0, 0, "R11 reserved code holds");
    drive(1, 3'd2, 8'h10, 0, 0, 0, 0, 0, "R10 R4 set index width strobes");
    drive(1, 3'd2, 8'h10, 0, 0, 0, 0, 0, "R10 repeated set no strobe");
    drive(1, 3'd2, 8'h0C, 0, 0, 0, 0, 0, "R4 set decimal and irq mask");
    drive(1, 3'd5, 8'h00, 4'b1010, 4'b1111, 0, 0, 0, "R8 update N and Z only");
    drive(1, 3'd5, 8'h00, 4'b0101, 4'b0100, 0, 0, 0, "R8 update V and C");
    drive(1, 3'd6, 8'h00, 0, 0, 16'h1234, 16'h1234, 0, "R9 equal wide compare");
    drive(1, 3'd6, 8'h00, 0, 0, 16'h0001, 16'h0002, 0, "R9 wide borrow");
    drive(1, 3'd6, 8'h00, 0, 0, 16'h0180, 16'h0280, 1, "R9 narrow via index width");
    drive(1, 3'd6, 8'h00, 0, 0, 16'h0180, 16'h0280, 0, "R9 wide via accum width");
    drive(1, 3'd4, 8'hC3, 0, 0, 0, 0, 0, "R7 load native byte");
    drive(1, 3'd3, 8'h00, 0, 0, 0, 0, 0, "R6 R10 exchange into emulation forces widths");
    drive(1, 3'd2, 8'h01, 0, 0, 0, 0, 0, "R4 set carry in emulation");
    drive(1, 3'd3, 8'h00, 0, 0, 0, 0, 0, "R6 R2 exchange back keeps widths");
    drive(1, 3'd1, 8'h20, 0, 0, 0, 0, 0, "R3 R2 clear accum width only");
    drive(0, 3'd0, 8'h00, 0, 0, 0, 0, 0, "R11 idle");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule